// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block is the controller-side state machine that takes a double-data-rate SDRAM from power-on to a usable state. After reset it holds the clock-enable pin low while the clock settles. It then raises clock-enable with a NOP and walks through a fixed series of commands: precharge of all banks, an extended mode register write that turns the DLL on, a mode register write that resets the DLL, a wait for DLL lock, a second precharge of all banks, a programmable number of auto-refreshes, and a final mode register write with the DLL-reset bit cleared. Every gap between two events is a module parameter given in clock cycles. Every cycle between commands carries a NOP.

The initial CAS latency, burst length and burst type come from input ports. They are captured at the first clock edge after reset is released, and the sequencer encodes them into the mode register fields. When the sequence is complete, `init_done` goes high. It stays high until the next reset. An outer controller that needs a new DLL reset, for example after a clock frequency change, asserts reset again and the whole sequence runs a second time. All outputs are registered. Counting edges from the first rising clock edge after reset release, a command decided at edge k appears on the pins just after edge k.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and after release up to edge T_STABLE, `cke`=0, the pins carry NOP, and `init_done`=0. `cke` rises just after edge T_STABLE and does not fall again before reset.
- R2: Every cycle without a listed command carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) with `ba`=0 and `addr`=0. No two commands are adjacent.
- R3: The first precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, addr bit 10 = 1, all other address bits 0, ba=0) appears T_CKE edges after `cke` rises.
- R4: The extended mode register write (all four command pins low, ba=1, addr all 0, so bit 0 = 0 enables the DLL) appears T_RP edges after the first precharge.
- R5: The DLL-reset mode register write appears T_MRD edges after the extended write. It has all four command pins low and ba=0. Its address fields are: bits 2:0 burst-length code, bit 3 burst type (1 = interleaved), bits 6:4 CAS latency code, bit 8 = 1, and all other bits 0.
- R6: The second precharge-all appears max(T_MRD, T_DLL) edges after the DLL-reset write.
- R7: Exactly N_REF auto-refreshes (cs_n=0, ras_n=0, cas_n=0, we_n=1, ba=0, addr=0) follow. The first comes T_RP edges after the second precharge, and consecutive refreshes are T_RFC edges apart.
- R8: The final mode register write appears T_RFC edges after the last refresh. Its fields are the same as in R5, except that bit 8 = 0.
- R9: `init_done` rises T_MRD edges after the final mode register write and stays high. While it is high, `cke`=1 and the pins carry NOP.
- R10: CAS latency input values 3, 4 and 5 encode to field codes 3'b011, 3'b100 and 3'b101. Values below 3 encode as 3, and values above 5 encode as 5.
- R11: Burst length input values 2, 4 and 8 encode to codes 3'b001, 3'b010 and 3'b011. Any other value encodes as 3'b010.
- R12: The configuration inputs are captured at the first edge after reset release. Later changes to them have no effect on either mode register write.
- R13: Asserting reset in the middle of the sequence returns every output to its reset state at once. After release, the sequence restarts from the stable-clock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; releasing it starts the sequence |
| cfg_cas_lat | input | 3 | Initial CAS latency in clocks |
| cfg_burst_len | input | 4 | Initial burst length in beats |
| cfg_interleave | input | 1 | Initial burst type, 1 = interleaved |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Row/mode address |
| init_done | output | 1 | High once the sequence is complete |

## Verification
The embedded properties assume that every post-command gap parameter (T_RP, T_MRD, T_RFC, max(T_MRD, T_DLL)) is at least two cycles, so that a command is always followed by a NOP. They also assume that reset is the only way to restart the sequence. The bench only picks parameters that meet this. It changes the configuration inputs only while reset is held, or after the capture edge in the one run that checks R12. It drives reset and the configuration one time unit after a rising edge and samples on the falling edge. That way the capture edge always sees settled values, and the model's edge count matches the design's edge count.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_STABLE, ST_PRE1, ST_EMRS, ST_DLLRST, ST_PRE2,
    ST_REF, ST_MRS, ST_FIN, ST_DONE
  } init_step_t;

  typedef enum logic [2:0] {OP_NOP, OP_PRE, OP_EMRS, OP_MRS, OP_REF} init_op_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t op_pins(input init_op_t op);
    cmd_pins_t p;
    case (op)
      OP_PRE:           p = 4'b0010;
      OP_EMRS, OP_MRS:  p = 4'b0000;
      OP_REF:           p = 4'b0001;
      default:          p = 4'b0111;
    endcase
    return p;
  endfunction

  function automatic logic [2:0] cl_field(input logic [2:0] cl);
    if (cl < 3'd3)      return 3'd3;
    else if (cl > 3'd5) return 3'd5;
    else                return cl;
  endfunction

  function automatic logic [2:0] bl_field(input logic [3:0] beats);
    case (beats)
      4'd2:    return 3'd1;
      4'd4:    return 3'd2;
      4'd8:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic int max_u(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= INIT;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2: an expired timer stays expired until reloaded
  p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/init_pin_drive.sv
module init_pin_drive import ddr_init_pkg::*; #(
  parameter int ROW_W = 12,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  init_op_t         op,
  input  logic             dll_rst,
  input  logic [2:0]       cl_code,
  input  logic [2:0]       bl_code,
  input  logic             bt,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr
);
  localparam int A_ALL_BANKS = 10;
  localparam int A_DLL_RESET = 8;

  cmd_pins_t        pins_d;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] addr_d;

  always_comb begin
    pins_d = op_pins(op);
    ba_d   = '0;
    addr_d = '0;
    case (op)
      OP_PRE:  addr_d[A_ALL_BANKS] = 1'b1;
      OP_EMRS: ba_d[0] = 1'b1;
      OP_MRS: begin
        addr_d[2:0]         = bl_code;
        addr_d[3]           = bt;
        addr_d[6:4]         = cl_code;
        addr_d[A_DLL_RESET] = dll_rst;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      ba   <= '0;
      addr <= '0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= pins_d;
      ba   <= ba_d;
      addr <= addr_d;
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq import ddr_init_pkg::*; #(
  parameter int T_STABLE = 50000,
  parameter int T_CKE    = 2,
  parameter int T_RP     = 5,
  parameter int T_MRD    = 2,
  parameter int T_DLL    = 200,
  parameter int T_RFC    = 19,
  parameter int N_REF    = 2,
  parameter int ROW_W    = 12,
  parameter int BA_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_cas_lat,
  input  logic [3:0]       cfg_burst_len,
  input  logic             cfg_interleave,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done
);
  localparam int DLL_GAP = max_u(T_MRD, T_DLL);
  localparam int GAP_MAX = max_u(T_STABLE, max_u(DLL_GAP, max_u(T_RFC, max_u(T_RP, T_CKE))));
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int REF_W   = $clog2(N_REF + 1);

  init_step_t       step_q, step_d;
  logic             tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             ev_cke, ev_done, cmd_fire, dll_rst;
  init_op_t         op;
  logic [REF_W-1:0] ref_cnt;
  logic             cfg_taken, cfg_bt;
  logic [2:0]       cfg_cl, cfg_bl;
  logic             cke_q, done_q;

  always_comb begin
    step_d   = step_q;
    ev_cke   = 1'b0;
    ev_done  = 1'b0;
    cmd_fire = 1'b0;
    dll_rst  = 1'b0;
    op       = OP_NOP;
    tmr_val  = '0;
    if (tmr_zero) begin
      case (step_q)
        ST_STABLE: begin ev_cke = 1'b1; tmr_val = CNT_W'(T_CKE - 1); step_d = ST_PRE1; end
        ST_PRE1:   begin cmd_fire = 1'b1; op = OP_PRE;  tmr_val = CNT_W'(T_RP - 1);  step_d = ST_EMRS; end
        ST_EMRS:   begin cmd_fire = 1'b1; op = OP_EMRS; tmr_val = CNT_W'(T_MRD - 1); step_d = ST_DLLRST; end
        ST_DLLRST: begin
          cmd_fire = 1'b1; op = OP_MRS; dll_rst = 1'b1;
          tmr_val = CNT_W'(DLL_GAP - 1); step_d = ST_PRE2;
        end
        ST_PRE2:   begin cmd_fire = 1'b1; op = OP_PRE;  tmr_val = CNT_W'(T_RP - 1);  step_d = ST_REF; end
        ST_REF: begin
          cmd_fire = 1'b1; op = OP_REF; tmr_val = CNT_W'(T_RFC - 1);
          if (ref_cnt == REF_W'(N_REF - 1)) step_d = ST_MRS;
        end
        ST_MRS:    begin cmd_fire = 1'b1; op = OP_MRS;  tmr_val = CNT_W'(T_MRD - 1); step_d = ST_FIN; end
        ST_FIN:    begin ev_done = 1'b1; step_d = ST_DONE; end
        default:   step_d = ST_DONE;
      endcase
    end
  end

  assign tmr_load = ev_cke | ev_done | cmd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q    <= ST_STABLE;
      ref_cnt   <= '0;
      cke_q     <= 1'b0;
      done_q    <= 1'b0;
      cfg_taken <= 1'b0;
      cfg_cl    <= 3'd3;
      cfg_bl    <= 3'd2;
      cfg_bt    <= 1'b0;
    end else begin
      step_q <= step_d;
      if (cmd_fire && op == OP_REF) ref_cnt <= ref_cnt + 1'b1;
      if (ev_cke)  cke_q  <= 1'b1;
      if (ev_done) done_q <= 1'b1;
      if (!cfg_taken) begin
        cfg_taken <= 1'b1;
        cfg_cl    <= cl_field(cfg_cas_lat);
        cfg_bl    <= bl_field(cfg_burst_len);
        cfg_bt    <= cfg_interleave;
      end
    end
  end

  init_gap_timer #(.CNT_W(CNT_W), .INIT(CNT_W'(T_STABLE - 1))) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  init_pin_drive #(.ROW_W(ROW_W), .BA_W(BA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .op(op), .dll_rst(dll_rst),
    .cl_code(cfg_cl), .bl_code(cfg_bl), .bt(cfg_bt),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  assign cke       = cke_q;
  assign init_done = done_q;

  logic pins_nop;
  assign pins_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);

  // R1: clock enable never drops once raised
  p_cke_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  // R2: nothing but NOP while clock enable is low
  p_nop_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> pins_nop);
  // R2: every command is followed by a NOP cycle
  p_cmd_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_nop |=> pins_nop);
  // R7: refresh count never passes its limit
  p_ref_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt <= REF_W'(N_REF));
  // R9: done is sticky and the bus is quiet afterwards
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cke && pins_nop));
  // R12: captured configuration never moves
  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_taken |=> ($stable(cfg_cl) && $stable(cfg_bl) && $stable(cfg_bt)));

endmodule

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;
  localparam int P_STABLE = 40;
  localparam int P_CKE    = 3;
  localparam int P_RP     = 5;
  localparam int P_MRD    = 2;
  localparam int P_DLL    = 200;
  localparam int P_RFC    = 17;
  localparam int P_NREF   = 3;
  localparam int ROW_W    = 12;
  localparam int BA_W     = 2;

  localparam int E_CKE  = P_STABLE;
  localparam int E_PRE1 = E_CKE + P_CKE;
  localparam int E_EMRS = E_PRE1 + P_RP;
  localparam int E_DLL  = E_EMRS + P_MRD;
  localparam int E_PRE2 = E_DLL + ((P_DLL > P_MRD) ? P_DLL : P_MRD);
  localparam int E_REF0 = E_PRE2 + P_RP;
  localparam int E_MRS  = E_REF0 + P_NREF * P_RFC;
  localparam int E_DONE = E_MRS + P_MRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_cas_lat = 3'd3;
  logic [3:0] cfg_burst_len = 4'd4;
  logic cfg_interleave = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [BA_W-1:0] ba;
  logic [ROW_W-1:0] addr;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .T_STABLE(P_STABLE), .T_CKE(P_CKE), .T_RP(P_RP), .T_MRD(P_MRD),
    .T_DLL(P_DLL), .T_RFC(P_RFC), .N_REF(P_NREF), .ROW_W(ROW_W), .BA_W(BA_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_burst_len(cfg_burst_len),
    .cfg_interleave(cfg_interleave), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
  );

  int errors = 0;
  int checks = 0;
  int edge_n = 0;
  bit checking = 1'b0;
  bit restarted = 1'b0;
  bit cfg_moved = 1'b0;
  bit finished = 1'b0;
  int exp_cl, exp_bl, exp_bt;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;

  function automatic int cl_ref(input int v);
    if (v <= 3) return 3;
    if (v >= 5) return 5;
    return v;
  endfunction

  function automatic int bl_ref(input int beats);
    if (beats == 8) return 3;
    if (beats == 2) return 1;
    return 2;
  endfunction

  function automatic int mode_word(input bit dll);
    return (dll ? 256 : 0) + exp_cl * 16 + exp_bt * 8 + exp_bl;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", tag, what, act, exp, edge_n);
    end
  endtask

  // cycle-by-cycle reference model, sampled on the falling edge
  always @(negedge clk) begin
    int k, e_cmd, e_ba, e_addr, e_cke, e_done;
    string tag;
    if (checking) begin
      k = edge_n; e_cmd = 7; e_ba = 0; e_addr = 0; e_cke = 0; e_done = 0;
      if (!rst_n) begin
        tag = restarted ? "R13" : "R1";
      end else begin
        e_cke  = (k >= E_CKE) ? 1 : 0;
        e_done = (k >= E_DONE) ? 1 : 0;
        tag = (k < E_CKE) ? "R1" : ((k >= E_DONE) ? "R9" : "R2");
        if (k == E_PRE1 || k == E_PRE2) begin
          e_cmd = 2; e_addr = 1024; tag = (k == E_PRE1) ? "R3" : "R6";
        end else if (k == E_EMRS) begin
          e_cmd = 0; e_ba = 1; tag = "R4";
        end else if (k == E_DLL) begin
          e_cmd = 0; e_addr = mode_word(1'b1); tag = "R5";
        end else if (k >= E_REF0 && k < E_MRS && ((k - E_REF0) % P_RFC) == 0) begin
          e_cmd = 1; tag = "R7";
        end else if (k == E_MRS) begin
          e_cmd = 0; e_addr = mode_word(1'b0); tag = "R8";
        end
        if (k == E_DLL || k == E_MRS) begin
          chk("R10", "cas latency field", int'(addr[6:4]), exp_cl);
          chk("R11", "burst length field", int'(addr[2:0]), exp_bl);
          if (cfg_moved) chk("R12", "captured fields", int'(addr[6:0]), exp_cl * 16 + exp_bt * 8 + exp_bl);
        end
      end
      chk(tag, "cmd pins", int'({cs_n, ras_n, cas_n, we_n}), e_cmd);
      chk(tag, "cke", int'(cke), e_cke);
      chk(tag, "init_done", int'(init_done), e_done);
      chk(tag, "ba", int'(ba), e_ba);
      chk(tag, "addr", int'(addr), e_addr);
    end
  end

  task automatic run(input int cl, input int beats, input bit il, input bit move, input int stop_at);
    @(posedge clk); #1;
    rst_n = 1'b0;
    cfg_cas_lat = 3'(cl); cfg_burst_len = 4'(beats); cfg_interleave = il;
    exp_cl = cl_ref(cl); exp_bl = bl_ref(beats); exp_bt = il ? 1 : 0;
    cfg_moved = move;
    checking = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    if (move) begin
      cfg_cas_lat = 3'd3; cfg_burst_len = 4'd2; cfg_interleave = ~il;
    end
    while (edge_n < stop_at) @(posedge clk);
    #1;
  endtask

  initial begin
    run(3, 4, 1'b0, 1'b0, E_DONE + 6);
    run(5, 8, 1'b1, 1'b1, E_DONE + 6);
    run(4, 2, 1'b0, 1'b0, 150);
    restarted = 1'b1;
    run(7, 6, 1'b1, 1'b0, E_DONE + 6);
    restarted = 1'b0;
    run(1, 3, 1'b0, 1'b0, E_DONE + 6);
    @(negedge clk);
    checking = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule